// File: doc/BRIEF.md
# Card Write-Access Verification Controller

This block decides whether a smart-card memory may be written. It keeps a small security store: a 3-bit attempt counter and three secret reference bytes. From a stream of decoded card commands it runs an unlock procedure. The procedure first writes a lowered attempt counter. It then compares three verification bytes, one at a time and in a fixed order, against the reference bytes. If all three match, write access is granted and stays granted until the next power-on reset.

A failed attempt gives the cleared counter bit back to nobody, so the counter limits how many guesses can be made. If an attempt fails while the counter is already all zeros, the block locks for good. Every compare holds the command stream for the same number of cycles, whatever its outcome. Until access is granted, a read of the reference bytes returns zero.

Commands arrive on a valid/ready stream. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Read data leave on a valid/ready response stream. A response stays on the port, unchanged, until `rsp_ready` takes it. While a response waits, no new command is accepted, so back-pressure on the response side stalls the command side. The non-volatile contents (counter, reference bytes, lock flag) are modelled as registers. They are loaded through the `ld_*` pins, and reset leaves them alone.

Top module: `card_wr_guard`

## Requirements
- R1: A read command (op 0) returns `{5'b0, counter}` at address 0. It returns reference byte k at address k (k = 1..3) only while access is granted, and 0x00 at those addresses otherwise. Every other address reads 0x00. Reference byte k is loaded from `ld_ref[8k-1:8k-8]`.
- R2: `cmd_ready` is low while a compare is in progress or a response is waiting. The response appears one cycle after its read is accepted, and holds its data until `rsp_ready` is high.
- R3: A write command (op 1) to address 0 carrying exactly 24 bits, whose data bits [2:0] only clear counter bits, stores those bits and arms the procedure. This holds only while the block is neither granted nor locked.
- R4: A counter write that tries to set a counter bit, or that carries other than 24 bits, fails the attempt and leaves the counter unchanged. Until access is granted, the counter never gains a set bit.
- R5: After an armed start, three compare commands (op 2) to addresses 1, 2 and 3 in that order, each with 24 bits and data equal to the matching reference byte, raise `wr_grant`.
- R6: While armed, any non-compare command fails the attempt and returns the block to idle. So does a compare with a wrong address, wrong data or a bit count other than 24. The counter keeps the value written at the start.
- R7: A failure while the counter is 0 sets `perm_lock`. While locked, counter writes and compares have no effect and `wr_grant` never rises.
- R8: Every accepted compare holds `cmd_ready` low for exactly CMP_LAT cycles (default 4), whether it matches or not.
- R9: `wr_grant` stays high until reset. Reset clears the grant and the procedure state, and keeps the counter, the reference bytes and `perm_lock`.
- R10: While granted, a 24-bit write to address 0 stores any counter value, setting bits included. A 24-bit write to address k (1..3) replaces reference byte k.
- R11: A compare issued while no procedure is armed changes nothing. A later correct compare series still does not grant access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ld_en | input | 1 | Load the non-volatile store from the `ld_*` values |
| ld_ctr | input | 3 | Attempt counter value to load |
| ld_ref | input | 24 | Three reference bytes to load, byte 1 in the low bits |
| ld_lock | input | 1 | Lock flag value to load |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_op | input | 2 | 0 read, 1 write, 2 compare, 3 any other card command |
| cmd_addr | input | 8 | Security-store address |
| cmd_data | input | 8 | Write data or verification byte |
| cmd_bits | input | 6 | Number of bits the command frame carried |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_data | output | 8 | Read response byte |
| wr_grant | output | 1 | Write access granted |
| perm_lock | output | 1 | Write access disabled for good |

## Verification
The assertions check, on every cycle, the properties that hold no matter what the commands were. These are: the grant and the lock never clear on their own, the counter only loses bits before a grant, and the compare stall is exactly CMP_LAT cycles long. They also check that a waiting response is held steady and that the reference bytes read as zero without a grant. Which command orders really grant access, and which ones fail an attempt, take the bench's scenarios to show. The same holds for whether a failure at a zero counter locks the block and what survives a reset. Each scenario is run against a behavioural model that is compared every cycle.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CMP   = 2'd2,
    OP_OTHER = 2'd3
  } cwg_op_e;

  // step value equals the reference address expected next
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REF1 = 2'd1,
    SQ_REF2 = 2'd2,
    SQ_REF3 = 2'd3
  } cwg_seq_e;
endpackage

// File: rtl/cwg_store.sv
module cwg_store #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int CW   = 3,
  parameter int NREF = 3
) (
  input  logic               clk,
  input  logic               ld_en,
  input  logic [CW-1:0]      ld_ctr,
  input  logic [NREF*DW-1:0] ld_ref,
  input  logic               ld_lock,
  input  logic               ctr_we,
  input  logic [CW-1:0]      ctr_wd,
  input  logic               ref_we,
  input  logic [AW-1:0]      ref_sel,
  input  logic [DW-1:0]      ref_wd,
  input  logic               lock_set,
  input  logic               granted,
  input  logic [AW-1:0]      rd_addr,
  output logic [CW-1:0]      ctr_q,
  output logic [NREF*DW-1:0] ref_q,
  output logic               lock_q,
  output logic [DW-1:0]      rd_data
);
  logic [NREF-1:0][DW-1:0] ref_r;

  // non-volatile cells: no reset, loaded externally
  always_ff @(posedge clk) begin
    if (ld_en) begin
      ctr_q  <= ld_ctr;
      lock_q <= ld_lock;
    end else begin
      if (ctr_we)   ctr_q  <= ctr_wd;
      if (lock_set) lock_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    always_ff @(posedge clk) begin
      if (ld_en)
        ref_r[g] <= ld_ref[g*DW +: DW];
      else if (ref_we && ref_sel == AW'(g + 1))
        ref_r[g] <= ref_wd;
    end
    assign ref_q[g*DW +: DW] = ref_r[g];
  end

  // secret bytes are hidden until access is granted
  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = DW'(ctr_q);
    for (int i = 0; i < NREF; i++)
      if (granted && rd_addr == AW'(i + 1)) rd_data = ref_r[i];
  end
endmodule

// File: rtl/cwg_seq.sv
module cwg_seq
  import cwg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int CW         = 3,
  parameter int NREF       = 3,
  parameter int BW         = 6,
  parameter int FRAME_BITS = 24,
  parameter int CMP_LAT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [1:0]         op,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      data,
  input  logic [BW-1:0]      bits,
  input  logic [CW-1:0]      ctr_q,
  input  logic [NREF*DW-1:0] ref_q,
  input  logic               lock_q,
  output logic               busy,
  output logic               grant,
  output logic               ctr_we,
  output logic [CW-1:0]      ctr_wd,
  output logic               ref_we,
  output logic [AW-1:0]      ref_sel,
  output logic [DW-1:0]      ref_wd,
  output logic               lock_set
);
  localparam int LW = $clog2(CMP_LAT + 1);

  cwg_seq_e       state;
  logic [LW-1:0]  lat_cnt;
  logic           live_q, ok_q;
  logic           bits_ok, in_seq, armed, done, imm_fail, cmp_fail, fail;
  logic           is_wr0;
  logic [DW-1:0]  exp_byte;

  assign bits_ok = bits == BW'(FRAME_BITS);
  assign in_seq  = state != SQ_IDLE;
  assign armed   = !grant && !lock_q;
  assign done    = lat_cnt == LW'(1);
  assign busy    = lat_cnt != '0;
  assign is_wr0  = op == OP_WRITE && addr == '0;

  always_comb begin
    exp_byte = '0;
    for (int i = 0; i < NREF; i++)
      if (state == cwg_seq_e'(i + 1)) exp_byte = ref_q[i*DW +: DW];
  end

  assign ctr_wd  = data[CW-1:0];
  assign ctr_we  = fire && is_wr0 && bits_ok &&
                   (grant || (armed && !in_seq && (data[CW-1:0] & ~ctr_q) == '0));
  assign ref_we  = fire && op == OP_WRITE && grant && bits_ok;
  assign ref_sel = addr;
  assign ref_wd  = data;

  assign imm_fail = fire && armed && op != OP_CMP && (in_seq || (is_wr0 && !ctr_we));
  assign cmp_fail = done && live_q && !ok_q;
  assign fail     = imm_fail || cmp_fail;
  assign lock_set = fail && ctr_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      lat_cnt <= '0;
      live_q  <= 1'b0;
      ok_q    <= 1'b0;
      grant   <= 1'b0;
    end else begin
      if (fire && op == OP_CMP) begin
        lat_cnt <= LW'(CMP_LAT);
        live_q  <= armed && in_seq;
        ok_q    <= bits_ok && addr == AW'(state) && data == exp_byte;
      end else if (busy) begin
        lat_cnt <= lat_cnt - LW'(1);
      end

      if (ctr_we && !grant) state <= SQ_REF1;

      if (done && live_q && ok_q) begin
        case (state)
          SQ_REF1: state <= SQ_REF2;
          SQ_REF2: state <= SQ_REF3;
          SQ_REF3: begin
            state <= SQ_IDLE;
            grant <= 1'b1;
          end
          default: state <= SQ_IDLE;
        endcase
      end

      if (fail) state <= SQ_IDLE;
    end
  end
endmodule

// File: rtl/card_wr_guard.sv
module card_wr_guard
  import cwg_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int CW         = 3,
  parameter int NREF       = 3,
  parameter int BW         = 6,
  parameter int FRAME_BITS = 24,
  parameter int CMP_LAT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [CW-1:0]      ld_ctr,
  input  logic [NREF*DW-1:0] ld_ref,
  input  logic               ld_lock,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [AW-1:0]      cmd_addr,
  input  logic [DW-1:0]      cmd_data,
  input  logic [BW-1:0]      cmd_bits,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DW-1:0]      rsp_data,
  output logic               wr_grant,
  output logic               perm_lock
);
  logic               fire, busy;
  logic               ctr_we, ref_we, lock_set;
  logic [CW-1:0]      ctr_wd, ctr_q;
  logic [AW-1:0]      ref_sel;
  logic [DW-1:0]      ref_wd, rd_data;
  logic [NREF*DW-1:0] ref_q;

  assign cmd_ready = !busy && !rsp_valid;
  assign fire      = cmd_valid && cmd_ready;

  cwg_seq #(
    .DW(DW), .AW(AW), .CW(CW), .NREF(NREF), .BW(BW),
    .FRAME_BITS(FRAME_BITS), .CMP_LAT(CMP_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(cmd_op), .addr(cmd_addr),
    .data(cmd_data), .bits(cmd_bits), .ctr_q(ctr_q), .ref_q(ref_q),
    .lock_q(perm_lock), .busy(busy), .grant(wr_grant), .ctr_we(ctr_we),
    .ctr_wd(ctr_wd), .ref_we(ref_we), .ref_sel(ref_sel), .ref_wd(ref_wd),
    .lock_set(lock_set)
  );

  cwg_store #(.DW(DW), .AW(AW), .CW(CW), .NREF(NREF)) u_store (
    .clk(clk), .ld_en(ld_en), .ld_ctr(ld_ctr), .ld_ref(ld_ref),
    .ld_lock(ld_lock), .ctr_we(ctr_we), .ctr_wd(ctr_wd), .ref_we(ref_we),
    .ref_sel(ref_sel), .ref_wd(ref_wd), .lock_set(lock_set),
    .granted(wr_grant), .rd_addr(cmd_addr), .ctr_q(ctr_q), .ref_q(ref_q),
    .lock_q(perm_lock), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && cmd_op == OP_READ) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cwg_chk.sv
module cwg_chk #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int CW      = 3,
  parameter int NREF    = 3,
  parameter int CMP_LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_en,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          wr_grant,
  input logic          perm_lock,
  input logic [CW-1:0] ctr_q
);
  localparam int LW = $clog2(CMP_LAT + 1);
  logic [LW-1:0] stall_cnt;
  logic          acc, secret_rd;

  assign acc       = cmd_valid && cmd_ready;
  assign secret_rd = acc && cmd_op == 2'd0 && cmd_addr != '0 && cmd_addr <= AW'(NREF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt <= '0;
    else if (acc && cmd_op == 2'd2) stall_cnt <= LW'(CMP_LAT);
    else if (stall_cnt != '0) stall_cnt <= stall_cnt - LW'(1);
  end

  // R9
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> wr_grant);
  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock && !ld_en |=> perm_lock);
  // R7
  lock_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_grant) |-> !perm_lock);
  // R4
  ctr_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_grant && !ld_en |=> (ctr_q & ~$past(ctr_q)) == '0);
  // R8
  cmp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt != '0 |-> !cmd_ready);
  // R8
  cmp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt == LW'(1) && !rsp_valid |=> cmd_ready);
  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R2
  rsp_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  // R1
  secret_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    secret_rd && !wr_grant |=> rsp_data == '0);
endmodule

bind card_wr_guard cwg_chk #(
  .DW(DW), .AW(AW), .CW(CW), .NREF(NREF), .CMP_LAT(CMP_LAT)
) u_cwg_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .wr_grant(wr_grant), .perm_lock(perm_lock), .ctr_q(ctr_q)
);

// File: tb/card_wr_guard_bench.sv
module card_wr_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CMP_LAT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_ctr = '0;
  logic [23:0] ld_ref = '0;
  logic        ld_lock = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [5:0]  cmd_bits = 6'd24;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        wr_grant, perm_lock;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R2";

  card_wr_guard #(.CMP_LAT(CMP_LAT)) u_card_wr_guard (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ctr(ld_ctr), .ld_ref(ld_ref),
    .ld_lock(ld_lock), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_bits(cmd_bits), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .wr_grant(wr_grant), .perm_lock(perm_lock)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  int   m_step, m_stall, m_ctr;
  bit   m_grant, m_lock, m_rsp_v, m_live, m_ok;
  int   m_rsp_d;
  int   m_ref [4];

  function automatic int model_read(int a);
    if (a == 0) return m_ctr;
    if (a >= 1 && a <= 3) return m_grant ? m_ref[a] : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit fire, ok24, fail, open;
    if (!rst_n) begin
      m_step = 0; m_stall = 0; m_grant = 0; m_rsp_v = 0;
      m_rsp_d = 0; m_live = 0; m_ok = 0;
    end else begin
      fire = cmd_valid && m_stall == 0 && !m_rsp_v;
      ok24 = cmd_bits == 6'd24;
      open = !m_grant && !m_lock;
      fail = 0;
      if (m_rsp_v && rsp_ready) m_rsp_v = 0;
      if (m_stall != 0) begin
        if (m_stall == 1 && m_live) begin
          if (!m_ok) fail = 1;
          else if (m_step == 3) begin m_grant = 1; m_step = 0; end
          else m_step = m_step + 1;
        end
        m_stall = m_stall - 1;
      end
      if (fire) begin
        case (cmd_op)
          2'd0: begin
            m_rsp_v = 1;
            m_rsp_d = model_read(int'(cmd_addr));
            if (open && m_step != 0) fail = 1;
          end
          2'd1: begin
            if (m_grant) begin
              if (ok24 && cmd_addr == 0) m_ctr = int'(cmd_data) & 7;
              else if (ok24 && cmd_addr >= 1 && cmd_addr <= 3) m_ref[cmd_addr] = int'(cmd_data);
            end else if (open) begin
              if (m_step != 0) fail = 1;
              else if (cmd_addr == 0) begin
                if (ok24 && ((int'(cmd_data) & 7) & ~m_ctr) == 0) begin
                  m_ctr = int'(cmd_data) & 7;
                  m_step = 1;
                end else fail = 1;
              end
            end
          end
          2'd2: begin
            m_stall = CMP_LAT;
            m_live  = open && m_step != 0;
            m_ok    = m_step != 0 && ok24 && int'(cmd_addr) == m_step &&
                      int'(cmd_data) == m_ref[m_step];
          end
          default: if (open && m_step != 0) fail = 1;
        endcase
      end
      if (fail) begin
        if (m_ctr == 0) m_lock = 1;
        m_step = 0;
      end
    end
    if (ld_en) begin
      m_ctr = int'(ld_ctr);
      m_lock = ld_lock;
      for (int i = 1; i <= 3; i++) m_ref[i] = int'(ld_ref[(i-1)*8 +: 8]);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (cmd_ready !== (m_stall == 0 && !m_rsp_v) || wr_grant !== m_grant ||
          perm_lock !== m_lock || rsp_valid !== m_rsp_v ||
          (m_rsp_v && int'(rsp_data) != m_rsp_d)) begin
        n_bad++;
        $display("FAIL %s cycle: rdy/grant/lock/rv/rd act %b%b%b%b/%0h exp %b%b%b%b/%0h",
                 cur_req, cmd_ready, wr_grant, perm_lock, rsp_valid, rsp_data,
                 (m_stall == 0 && !m_rsp_v), m_grant, m_lock, m_rsp_v, m_rsp_d);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a,
                      input logic [7:0] d, input logic [5:0] b);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_bits = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    send(2'd0, a, 8'h00, 6'd24);
    v = int'(rsp_data);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic cmp(input logic [7:0] a, input logic [7:0] d, input logic [5:0] b,
                     output int lat);
    send(2'd2, a, d, b);
    lat = 0;
    while (!cmd_ready) begin lat++; @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [5:0] b);
    send(2'd1, a, d, b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, lat;
    @(negedge clk);
    ld_en = 1'b1; ld_ctr = 3'b111; ld_ref = 24'h0F3CA5; ld_lock = 1'b0;
    @(negedge clk);
    ld_en = 1'b0;
    do_reset();

    cur_req = "R9";
    check("R9 reset grant", int'(wr_grant), 0);
    check("R2 reset ready", int'(cmd_ready), 1);
    check("R7 reset lock", int'(perm_lock), 0);

    cur_req = "R1";
    rd(8'd0, v); check("R1 counter read", v, 7);
    rd(8'd1, v); check("R1 masked ref1", v, 0);
    rd(8'd9, v); check("R1 undefined addr", v, 0);

    cur_req = "R11";
    cmp(8'd1, 8'hA5, 6'd24, lat);
    cmp(8'd2, 8'h3C, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R11 no grant unarmed", int'(wr_grant), 0);

    cur_req = "R3";
    wr(8'd0, 8'h03, 6'd24);
    rd(8'd0, v); check("R3 start write stored", v, 3);

    cur_req = "R6";
    wr(8'd0, 8'h03, 6'd24);
    cmp(8'd1, 8'hA5, 6'd24, lat); check("R8 match latency", lat, CMP_LAT);
    cmp(8'd2, 8'h00, 6'd24, lat); check("R8 mismatch latency", lat, CMP_LAT);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R6 mismatch no grant", int'(wr_grant), 0);
    rd(8'd0, v); check("R6 counter kept", v, 3);

    cur_req = "R4";
    wr(8'd0, 8'h07, 6'd24);
    rd(8'd0, v); check("R4 set bit refused", v, 3);
    wr(8'd0, 8'h01, 6'd23);
    rd(8'd0, v); check("R4 short frame refused", v, 3);

    cur_req = "R6";
    wr(8'd0, 8'h01, 6'd24);
    cmp(8'd1, 8'hA5, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R6 skipped address", int'(wr_grant), 0);
    wr(8'd0, 8'h01, 6'd24);
    cmp(8'd1, 8'hA5, 6'd24, lat);
    send(2'd3, 8'd0, 8'd0, 6'd24);
    cmp(8'd2, 8'h3C, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R6 foreign command", int'(wr_grant), 0);
    wr(8'd0, 8'h01, 6'd24);
    cmp(8'd1, 8'hA5, 6'd25, lat);
    cmp(8'd2, 8'h3C, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R6 compare bit count", int'(wr_grant), 0);
    rd(8'd0, v); check("R6 counter after fails", v, 1);

    cur_req = "R5";
    wr(8'd0, 8'h00, 6'd24);
    cmp(8'd1, 8'hA5, 6'd24, lat);
    cmp(8'd2, 8'h3C, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R5 grant", int'(wr_grant), 1);
    check("R7 no lock on success", int'(perm_lock), 0);
    rd(8'd1, v); check("R1 ref1 visible", v, 8'hA5);
    rd(8'd3, v); check("R1 ref3 visible", v, 8'h0F);

    cur_req = "R10";
    wr(8'd0, 8'h07, 6'd24);
    rd(8'd0, v); check("R10 counter restored", v, 7);
    wr(8'd2, 8'h77, 6'd24);

    cur_req = "R2";
    rsp_ready = 1'b0;
    send(2'd0, 8'd2, 8'd0, 6'd24);
    repeat (3) @(negedge clk);
    check("R2 response held", int'(rsp_valid), 1);
    check("R2 held data", int'(rsp_data), 8'h77);
    check("R2 stalled ready", int'(cmd_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 response drained", int'(rsp_valid), 0);

    cur_req = "R9";
    do_reset();
    check("R9 grant cleared", int'(wr_grant), 0);
    rd(8'd0, v); check("R9 counter kept", v, 7);
    rd(8'd2, v); check("R9 ref masked again", v, 0);

    cur_req = "R7";
    wr(8'd0, 8'h00, 6'd24);
    cmp(8'd1, 8'h00, 6'd24, lat);
    check("R7 lock on zero counter", int'(perm_lock), 1);
    wr(8'd0, 8'h00, 6'd24);
    cmp(8'd1, 8'hA5, 6'd24, lat);
    cmp(8'd2, 8'h77, 6'd24, lat);
    cmp(8'd3, 8'h0F, 6'd24, lat);
    check("R7 locked no grant", int'(wr_grant), 0);
    do_reset();
    check("R9 lock survives reset", int'(perm_lock), 1);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule